// File: doc/BRIEF.md
# Flyback Flash Charger Controller

This block is the digital heart of a flyback charger for a photo-flash storage capacitor. It drives the gate of the primary power switch in boundary mode: the switch turns on, stays on until the primary current reaches its peak (or a maximum on-time expires), then stays off while the transformer dumps its energy into the secondary. When the flyback voltage on the switch node collapses to zero, the next on-phase begins. Analog comparators outside the block watch the switch node and the sense resistor. They hand the controller single-bit flags for peak current, zero kickback, full-voltage kickback, drain overvoltage and over-temperature.

A charge cycle can only begin on a rising edge of the charge-enable input, which sets an internal enable latch. The latch is cleared when charge-enable goes low, when the full-voltage flag is seen during the off-phase, or when a drain overvoltage is seen during the on-phase. Only the full-voltage stop pulls the active-low completion output low. An overvoltage stop is a latched fault that leaves the completion output high. Over-temperature pauses switching without touching the latch, so charging resumes on its own. A separate IGBT command input is passed straight to the IGBT gate output.

All asynchronous inputs except the IGBT command pass through a two-stage synchronizer before the state register.

Top module: `flash_charge_ctrl`

## Requirements
- R1: A rising edge of `chg_en_i` sets the enable latch, clears any completion or fault condition (`chg_done_n_o` returns to 1) and turns `sw_gate_o` on three clock edges after the change, unless over-temperature is active.
- R2: With `chg_en_i` low, `sw_gate_o` goes low three edges after the fall and stays low. The completion state is kept until the next rising edge.
- R3: In the on-phase, a peak-current flag turns `sw_gate_o` off three edges after it is raised.
- R4: The on-phase never lasts more than MAX_ON_CYC clock cycles. The on-time counter restarts at every turn-on.
- R5: In the off-phase, `sw_gate_o` stays off until the zero-kickback flag is seen, and then turns on three edges after that flag is raised.
- R6: A full-voltage flag seen in the off-phase stops charging and drives `chg_done_n_o` to 0. The same flag is ignored during the on-phase. After a stop, no restart occurs without a new rising edge of `chg_en_i`.
- R7: A drain-overvoltage flag seen in the on-phase, once the on-time count has reached BLANK_CYC, latches a fault and stops charging with `chg_done_n_o` held at 1. Before that count, the flag takes effect only when the count reaches BLANK_CYC. The flag is ignored in the off-phase.
- R8: Over-temperature forces `sw_gate_o` off three edges after it is raised, without clearing the enable latch. When it clears while `chg_en_i` is still high, a fresh on-phase with a full on-time budget starts three edges later.
- R9: `igbt_gate_o` equals `igbt_cmd_i` with no register in the path.
- R10: During and after reset, `sw_gate_o` is 0 and `chg_done_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chg_en_i | input | 1 | Charge enable (asynchronous) |
| igbt_cmd_i | input | 1 | IGBT command, buffered to the IGBT gate |
| pk_hit_i | input | 1 | Primary current has reached its peak |
| zero_kick_i | input | 1 | Switch-node kickback has fallen below the zero threshold |
| full_kick_i | input | 1 | Kickback shows the target output voltage |
| drain_ov_i | input | 1 | Drain overvoltage detected |
| over_temp_i | input | 1 | Die over-temperature |
| sw_gate_o | output | 1 | Power-switch gate command |
| chg_done_n_o | output | 1 | Charge complete, active low (0 = pull down the open-drain pin) |
| igbt_gate_o | output | 1 | IGBT gate drive |

## Verification
Every flag and charge-enable change reaches the switch and completion outputs on the third rising clock edge after it is applied: two synchronizer stages and then the state register. The IGBT gate follows its command with no clock delay. The bench changes inputs on falling edges and reads outputs on the third falling edge afterwards. When it measures on-phase lengths, it counts falling-edge samples of a high gate. Its expected lengths are computed from this three-edge delay, the on-time limit and the blanking count.

// File: rtl/flash_charge_pkg.sv
package flash_charge_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ON   = 2'd1,
        PH_OFF  = 2'd2
    } phase_e;

    // bit positions of the synchronized input vector
    localparam int FL_CHG  = 0;
    localparam int FL_PK   = 1;
    localparam int FL_ZC   = 2;
    localparam int FL_FULL = 3;
    localparam int FL_OVD  = 4;
    localparam int FL_OT   = 5;
    localparam int FL_NUM  = 6;

endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/ontime_limit.sv
module ontime_limit #(
    parameter int MAX_ON_CYC = 10000,
    parameter int BLANK_CYC  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic run_i,
    output logic limit_hit_o,
    output logic blank_done_o
);
    localparam int CNT_W = $clog2(MAX_ON_CYC + 1);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(MAX_ON_CYC - 1);
    localparam logic [CNT_W-1:0] BLANK = CNT_W'(BLANK_CYC);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i) begin
            cnt_d = '0;
        end else if (run_i && (cnt_q != LAST)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign limit_hit_o  = (cnt_q == LAST);
    assign blank_done_o = (cnt_q >= BLANK);

    // R4: the count never passes the last on-time slot
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R4: a restart request always brings the count back to zero
    assert_cnt_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (cnt_q == '0));

endmodule

// File: rtl/charge_seq.sv
module charge_seq
    import flash_charge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic chg_s_i,
    input  logic pk_s_i,
    input  logic zc_s_i,
    input  logic full_s_i,
    input  logic ovd_s_i,
    input  logic ot_s_i,
    input  logic limit_hit_i,
    input  logic blank_done_i,
    output logic cnt_restart_o,
    output logic cnt_run_o,
    output logic sw_on_o,
    output logic done_n_o
);
    typedef struct packed {
        phase_e phase;
        logic   en;
        logic   full;
        logic   fault;
        logic   chg_prev;
    } seq_t;

    seq_t st_d, st_q;
    logic rise;

    always_comb begin
        st_d          = st_q;
        cnt_restart_o = 1'b0;
        rise          = chg_s_i & ~st_q.chg_prev;
        st_d.chg_prev = chg_s_i;

        if (rise) begin
            st_d.en    = 1'b1;
            st_d.full  = 1'b0;
            st_d.fault = 1'b0;
            if (ot_s_i) begin
                st_d.phase = PH_IDLE;
            end else begin
                st_d.phase    = PH_ON;
                cnt_restart_o = 1'b1;
            end
        end else if (!chg_s_i) begin
            st_d.en    = 1'b0;
            st_d.phase = PH_IDLE;
        end else if (ot_s_i || !st_q.en) begin
            st_d.phase = PH_IDLE;
        end else begin
            unique case (st_q.phase)
                PH_IDLE: begin
                    st_d.phase    = PH_ON;
                    cnt_restart_o = 1'b1;
                end
                PH_ON: begin
                    if (ovd_s_i && blank_done_i) begin
                        st_d.fault = 1'b1;
                        st_d.en    = 1'b0;
                        st_d.phase = PH_IDLE;
                    end else if (pk_s_i || limit_hit_i) begin
                        st_d.phase = PH_OFF;
                    end
                end
                PH_OFF: begin
                    if (full_s_i) begin
                        st_d.full  = 1'b1;
                        st_d.en    = 1'b0;
                        st_d.phase = PH_IDLE;
                    end else if (zc_s_i) begin
                        st_d.phase    = PH_ON;
                        cnt_restart_o = 1'b1;
                    end
                end
                default: st_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, en: 1'b0, full: 1'b0, fault: 1'b0, chg_prev: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sw_on_o   = (st_q.phase == PH_ON);
    assign cnt_run_o = (st_q.phase == PH_ON);
    assign done_n_o  = ~st_q.full;

    // R1: the switch can only turn on while charge enable was high
    assert_on_needs_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_on_o) |-> $past(chg_s_i));

    // R6: completion is only reported out of an off-phase
    assert_full_from_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_n_o) |-> ($past(st_q.phase) == PH_OFF));

    // R6: a completed charge keeps the switch off
    assert_done_switch_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done_n_o |-> !sw_on_o);

    // R7: a fault never reports completion
    assert_fault_not_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.fault) |-> done_n_o);

    // R7: fault and completion never coexist
    assert_fault_full_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.fault && st_q.full));

endmodule

// File: rtl/flash_charge_ctrl.sv
module flash_charge_ctrl
    import flash_charge_pkg::*;
#(
    parameter int MAX_ON_CYC  = 10000,
    parameter int BLANK_CYC   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chg_en_i,
    input  logic igbt_cmd_i,
    input  logic pk_hit_i,
    input  logic zero_kick_i,
    input  logic full_kick_i,
    input  logic drain_ov_i,
    input  logic over_temp_i,
    output logic sw_gate_o,
    output logic chg_done_n_o,
    output logic igbt_gate_o
);
    logic [FL_NUM-1:0] raw_flags, syn_flags;
    logic cnt_restart, cnt_run, limit_hit, blank_done;

    always_comb begin
        raw_flags          = '0;
        raw_flags[FL_CHG]  = chg_en_i;
        raw_flags[FL_PK]   = pk_hit_i;
        raw_flags[FL_ZC]   = zero_kick_i;
        raw_flags[FL_FULL] = full_kick_i;
        raw_flags[FL_OVD]  = drain_ov_i;
        raw_flags[FL_OT]   = over_temp_i;
    end

    flag_sync #(.WIDTH(FL_NUM), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_flags),
        .sync_o  (syn_flags)
    );

    ontime_limit #(.MAX_ON_CYC(MAX_ON_CYC), .BLANK_CYC(BLANK_CYC)) u_ontime (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart_i    (cnt_restart),
        .run_i        (cnt_run),
        .limit_hit_o  (limit_hit),
        .blank_done_o (blank_done)
    );

    charge_seq u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .chg_s_i       (syn_flags[FL_CHG]),
        .pk_s_i        (syn_flags[FL_PK]),
        .zc_s_i        (syn_flags[FL_ZC]),
        .full_s_i      (syn_flags[FL_FULL]),
        .ovd_s_i       (syn_flags[FL_OVD]),
        .ot_s_i        (syn_flags[FL_OT]),
        .limit_hit_i   (limit_hit),
        .blank_done_i  (blank_done),
        .cnt_restart_o (cnt_restart),
        .cnt_run_o     (cnt_run),
        .sw_on_o       (sw_gate_o),
        .done_n_o      (chg_done_n_o)
    );

    assign igbt_gate_o = igbt_cmd_i;

    // R8: over-temperature held for a cycle forbids a turn-on
    assert_ot_blocks_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        syn_flags[FL_OT] |=> !$rose(sw_gate_o));

    // R10: reset leaves the switch off and completion released
    always_comb begin
        if (!rst_n) begin
            assert_reset_state_R10: assert (!sw_gate_o && chg_done_n_o);
        end
    end

endmodule

// File: tb/flash_charge_ctrl_bench.sv
module flash_charge_ctrl_bench;
    localparam int MAXC  = 12;
    localparam int BLANK = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chg = 0, igbt = 0, pk = 0, zc = 0, full = 0, ovd = 0, ot = 0;
    logic sw, done_n, igbt_g;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    flash_charge_ctrl #(.MAX_ON_CYC(MAXC), .BLANK_CYC(BLANK), .SYNC_STAGES(2)) u_flash_charge_ctrl (
        .clk(clk), .rst_n(rst_n), .chg_en_i(chg), .igbt_cmd_i(igbt),
        .pk_hit_i(pk), .zero_kick_i(zc), .full_kick_i(full), .drain_ov_i(ovd),
        .over_temp_i(ot), .sw_gate_o(sw), .chg_done_n_o(done_n), .igbt_gate_o(igbt_g)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // leaves the bench on the third falling edge after the enable rise
    task automatic start_charge();
        chg = 0; pk = 0; zc = 0; full = 0; ovd = 0; ot = 0;
        step(4);
        chg = 1;
        step(3);
        chk("R1 switch on after enable rise", sw, 1);
    endtask

    // counts high samples from now; raises pk / ovd at the given offsets
    task automatic measure(input int p_pk, input int p_ov, output int on_cnt);
        bit counting = 1;
        on_cnt = 0;
        for (int j = 0; j < MAXC + 12; j++) begin
            if (counting) begin
                if (sw) on_cnt++;
                else counting = 0;
            end
            if (j == p_pk) pk = 1;
            if (j == p_ov) ovd = 1;
            step(1);
        end
    endtask

    initial begin
        int n, exp_on;
        bit flt;
        step(3);
        chk("R10 reset switch", sw, 0);
        chk("R10 reset done", done_n, 1);
        rst_n = 1;
        step(2);
        chk("R10 idle switch", sw, 0);

        // R9: combinational buffer
        for (int v = 0; v < 4; v++) begin
            igbt = v[0];
            #1 chk("R9 igbt buffer", igbt_g, v[0]);
            step(1);
        end

        // R3 / R4: peak arrival swept across and past the on-time budget
        for (int p = 0; p <= MAXC; p++) begin
            start_charge();
            measure(p, 999, n);
            exp_on = (p + 3 < MAXC) ? p + 3 : MAXC;
            chk((p + 3 < MAXC) ? "R3 peak ends on-phase" : "R4 max on-time", n, exp_on);
        end

        // R5: off-phase waits for zero kickback
        start_charge();
        measure(999, 999, n);
        chk("R4 on-time without peak", n, MAXC);
        step(5);
        chk("R5 no restart without zero flag", sw, 0);
        zc = 1;
        step(2);
        chk("R5 not yet on", sw, 0);
        step(1);
        chk("R5 restart on zero flag", sw, 1);
        zc = 0;
        measure(999, 999, n);
        chk("R4 counter restarts each turn-on", n, MAXC);

        // R7: overvoltage swept across blanking and the on-time budget
        for (int p = 0; p <= MAXC; p++) begin
            start_charge();
            measure(999, p, n);
            exp_on = (p + 3 > BLANK + 1) ? p + 3 : BLANK + 1;
            flt = (exp_on <= MAXC);
            if (!flt) exp_on = MAXC;
            chk("R7 on length with overvoltage", n, exp_on);
            ovd = 0; zc = 1;
            step(4);
            chk("R7 fault latched / ignored off-phase", sw, flt ? 0 : 1);
            chk("R7 done stays high", done_n, 1);
            zc = 0;
        end

        // R1: new rise clears a fault
        start_charge();
        chk("R1 done after restart", done_n, 1);

        // R6: full flag during on-phase is ignored
        start_charge();
        full = 1;
        step(2);
        full = 0;
        measure(999, 999, n);
        chk("R6 full ignored in on-phase", n, MAXC - 2);
        chk("R6 done high after ignored full", done_n, 1);
        step(3);
        full = 1;
        step(2);
        chk("R6 done not yet low", done_n, 1);
        step(1);
        chk("R6 done low on full", done_n, 0);
        full = 0; zc = 1;
        step(5);
        chk("R6 no restart after full", sw, 0);
        zc = 0;
        chg = 0;
        step(4);
        chk("R2 done kept with enable low", done_n, 0);
        chg = 1;
        step(3);
        chk("R1 rise clears done", done_n, 1);
        chk("R1 rise restarts switch", sw, 1);

        // R2: enable fall stops switching
        chg = 0;
        step(2);
        chk("R2 switch held before latency", sw, 1);
        step(1);
        chk("R2 switch off after enable fall", sw, 0);
        zc = 1;
        step(5);
        chk("R2 stays off", sw, 0);
        zc = 0;

        // R8: thermal pause and resume
        start_charge();
        step(2);
        ot = 1;
        step(3);
        chk("R8 off on over-temperature", sw, 0);
        step(6);
        chk("R8 held off", sw, 0);
        ot = 0;
        step(3);
        chk("R8 resumes", sw, 1);
        measure(999, 999, n);
        chk("R8 full budget after resume", n, MAXC);
        chk("R8 done untouched", done_n, 1);

        // R1/R8: rise during over-temperature waits
        chg = 0; ot = 1;
        step(4);
        chg = 1;
        step(6);
        chk("R8 no start while hot", sw, 0);
        ot = 0;
        step(3);
        chk("R8 start after cooling", sw, 1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule